// File: doc/BRIEF.md
# Reversible Nibble Counter with Ripple Clock

A 4-bit binary counter that steps up or down by one on each rising clock edge while its active-low enable is asserted, wrapping modulo 16. An active-low load puts the parallel data onto the count outputs at once, with no clock, and takes priority over counting for as long as it is held. The value the counter keeps when the load is released is the data present at the load's falling edge or at the last rising clock edge during the load. For this reason the data must stay stable from its last clock edge until the load is released.

A terminal flag marks the boundary for the current direction: 15 when counting up, 0 when counting down. The flag is not masked by the enable. An active-low ripple-clock output pulses low during the low phase of the clock whenever the stage is enabled and at its boundary. Stages can be chained through it, either as the clock of the next stage or as that stage's enable.

Top module: `rev_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and load_ni is ignored.
- R2: With cnt_en_ni low, load_ni high and dir_down_i low (0 = up), count_o becomes (count_o + 1) mod 16 at each rising edge of clk_i.
- R3: With cnt_en_ni low, load_ni high and dir_down_i high (1 = down), count_o becomes (count_o - 1) mod 16 at each rising edge of clk_i.
- R4: With cnt_en_ni high, count_o holds across rising clock edges.
- R5: While load_ni is low, count_o equals data_i without any clock edge.
- R6: While load_ni is low, rising clock edges do not count. After release, count_o keeps the loaded value until the next enabled rising edge.
- R7: With dir_down_i low, term_o is high exactly when count_o is 15.
- R8: With dir_down_i high, term_o is high exactly when count_o is 0. A change of dir_down_i updates term_o at once, without a clock.
- R9: term_o does not depend on cnt_en_ni.
- R10: ripple_no is low exactly while cnt_en_ni is low, term_o is high and clk_i is low. It is high throughout the high phase of clk_i.
- R11: While cnt_en_ni is high, ripple_no stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| dir_down_i | input | 1 | Direction: 0 up, 1 down |
| load_ni | input | 1 | Asynchronous parallel load, active low |
| data_i | input | 4 | Parallel load value |
| count_o | output | 4 | Current count |
| term_o | output | 1 | Boundary flag for the current direction |
| ripple_no | output | 1 | Ripple clock, active low during clock-low phase |

## Verification
A count step lands one register after the rising edge, so the bench drives its inputs 1 ns after an edge and samples the count 1 ns after the next edge. Load, terminal flag and ripple clock have no register on their path, so the bench samples them 1 ns after the input or clock change that drives them. The ripple clock is sampled in both phases of every counting cycle: 1 ns after the falling edge, where it must follow the enable and the flag, and 1 ns after the rising edge, where it must be high. Loads are issued mid-cycle and held across a rising edge to show that the edge is ignored.

// File: rtl/rev_counter_pkg.sv
package rev_counter_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/rc_step.sv
module rc_step #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] nxt_o
);
  import rev_counter_pkg::*;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    if (dir_e'(down_i) == DIR_DOWN) nxt_o = cur_i - ONE;
    else                            nxt_o = cur_i + ONE;
  end
endmodule

// File: rtl/rc_term.sv
module rc_term #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             down_i,
  output logic             term_o
);
  import rev_counter_pkg::*;
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_comb begin
    if (dir_e'(down_i) == DIR_DOWN) term_o = (cur_i == '0);
    else                            term_o = (cur_i == TOP);
  end
endmodule

// File: rtl/rc_ripple.sv
module rc_ripple (
  input  logic clk_i,
  input  logic en_ni,
  input  logic term_i,
  output logic ripple_no
);
  // low only in clock-low phase of an enabled boundary cycle
  assign ripple_no = ~(~en_ni & term_i & ~clk_i);
endmodule

// File: rtl/rev_counter.sv
module rev_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_ni,
  input  logic             dir_down_i,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o,
  output logic             ripple_no
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  rc_step #(.WIDTH(WIDTH)) i_step (
    .cur_i (cnt_q),
    .down_i(dir_down_i),
    .nxt_o (cnt_nxt)
  );

  // load acts asynchronously; clock edges during load re-capture data
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!load_ni)   cnt_q <= data_i;
    else if (!cnt_en_ni) cnt_q <= cnt_nxt;
  end

  // transparent view of data while load is held
  assign count_o = (!load_ni && rst_ni) ? data_i : cnt_q;

  rc_term #(.WIDTH(WIDTH)) i_term (
    .cur_i (count_o),
    .down_i(dir_down_i),
    .term_o(term_o)
  );

  rc_ripple i_ripple (
    .clk_i    (clk_i),
    .en_ni    (cnt_en_ni),
    .term_i   (term_o),
    .ripple_no(ripple_no)
  );

  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(cnt_en_ni) && !$past(dir_down_i))
      |-> count_o == $past(count_o) + ONE);

  a_r3_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && !$past(cnt_en_ni) && $past(dir_down_i))
      |-> count_o == $past(count_o) - ONE);

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && $past(load_ni) && $past(cnt_en_ni))
      |-> count_o == $past(count_o));

  a_r10_high_phase: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ripple_no);

  a_r11_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_ni |-> ripple_no);
endmodule

// File: tb/test_rev_counter.sv
module test_rev_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_n = 1'b1;
  logic       dn = 1'b0;
  logic       ld_n = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] cnt;
  logic       term;
  logic       rip_n;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_cnt = '0;

  rev_counter #(.WIDTH(4)) i_rev_counter (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_ni(en_n), .dir_down_i(dn),
    .load_ni(ld_n), .data_i(din), .count_o(cnt), .term_o(term), .ripple_no(rip_n)
  );

  always #5 clk = ~clk;

  function automatic logic exp_term(input logic [3:0] c, input logic d);
    return d ? (c == 4'd0) : (c == 4'd15);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  // load value v mid-cycle, hold across one rising edge, release
  task automatic do_load(input logic [3:0] v);
    ld_n = 1'b0; din = v; #1;
    chk("R5 transparent load", cnt, v);
    edge_after();
    chk("R6 edge ignored during load", cnt, v);
    ld_n = 1'b1; #1;
    chk("R6 value kept after release", cnt, v);
    exp_cnt = v;
  endtask

  // n enabled cycles, checking ripple in both phases plus count and flag
  task automatic run(input logic d, input int n);
    dn = d; en_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      chk("R10 low phase ripple", rip_n, !exp_term(exp_cnt, d));
      @(posedge clk); #1;
      exp_cnt = d ? exp_cnt - 4'd1 : exp_cnt + 4'd1;
      chk(d ? "R3 count down" : "R2 count up", cnt, exp_cnt);
      chk(d ? "R8 term down" : "R7 term up", term, exp_term(exp_cnt, d));
      chk("R10 high phase ripple", rip_n, 1);
    end
  endtask

  initial begin
    #2;
    chk("R1 reset count", cnt, 0);
    ld_n = 1'b0; din = 4'd9; #1;
    chk("R1 load ignored in reset", cnt, 0);
    ld_n = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;

    // wrap up then down, full cycles
    do_load(4'd13);
    run(1'b0, 18);
    do_load(4'd2);
    run(1'b1, 18);

    // every load value, a few steps each way
    for (int v = 0; v < 16; v++) begin
      do_load(4'(v));
      run(1'b0, 2);
      run(1'b1, 3);
    end

    // hold with enable off: count steady, flag still shown, no pulse
    do_load(4'd15);
    dn = 1'b0; en_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R11 no pulse when disabled", rip_n, 1);
      chk("R9 term ignores enable", term, 1);
      edge_after();
      chk("R4 hold", cnt, 15);
    end

    // direction change while flag high
    dn = 1'b1; #1;
    chk("R8 dir change clears flag", term, 0);
    dn = 1'b0; #1;
    chk("R7 dir back sets flag", term, 1);
    do_load(4'd0);
    dn = 1'b1; #1;
    chk("R8 down flag at zero", term, 1);
    dn = 1'b0; #1;
    chk("R7 up flag cleared at zero", term, 0);

    // ripple pulse spans exactly the clock-low phase
    do_load(4'd15);
    dn = 1'b0; en_n = 1'b0;
    @(negedge clk); #1;
    chk("R10 low after falling edge", rip_n, 0);
    #3;
    chk("R10 low just before rising edge", rip_n, 0);
    @(posedge clk); #1;
    chk("R10 high after rising edge", rip_n, 1);
    chk("R2 wrap to zero", cnt, 0);

    // load issued in clock-low phase while counting
    @(negedge clk); #1;
    ld_n = 1'b0; din = 4'd7; #1;
    chk("R5 load in low phase", cnt, 7);
    @(posedge clk); #1;
    chk("R6 no count during load", cnt, 7);
    @(negedge clk); #1;
    ld_n = 1'b1; #1;
    chk("R6 value after release", cnt, 7);
    @(posedge clk); #1;
    chk("R2 count after load", cnt, 8);
    en_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule